// File: doc/BRIEF.md
# Two-World Configuration Register File

This block is a small bank of configuration registers placed next to a processor core. Every read or write it receives is judged against a two-world security model, secure and non-secure. Each register index belongs to one of three classes. A protected register can be reached only by secure accesses. A split register has one copy for each world. A shared register has a single copy that both worlds use.

The world an access counts as is not always the world the core runs in. While the core is in its supervising monitor mode, every access counts as secure. In that mode a copy-select bit chooses which copy of a split register is reached. The copy-select bit is bit 0 of protected register 0, so only secure code can change it. Outside monitor mode the core's own world picks the copy, and the copy-select bit has no effect.

Read data and the fault flag are registered, so both appear one cycle after the strobe. The fault flag marks an access that was refused, either because the index is not implemented or because non-secure code tried to reach a protected register.

Top module: `sbr_regfile`

## Requirements
- R1: With the default parameters, indices 0-1 are protected, indices 2-4 are split and indices 5-6 are shared. Indices 7-15 are not implemented.
- R2: Outside monitor mode (`mon_mode`=0), a split-register access reaches the secure copy when `core_ns`=0 and the non-secure copy when `core_ns`=1, whatever the copy-select bit holds.
- R3: In monitor mode, a split-register access reaches the secure copy when the copy-select bit is 0 and the non-secure copy when it is 1, whatever `core_ns` is.
- R4: In monitor mode, protected registers can be read and written without a fault, whatever the copy-select bit and `core_ns` are.
- R5: A non-secure access (`core_ns`=1, `mon_mode`=0) to a protected register raises `fault`, returns zero read data and leaves the register unchanged.
- R6: A shared register has one storage location. A write from either world updates it, and both worlds read the same value.
- R7: The copy-select bit is bit 0 of protected register 0. A non-secure write cannot change it.
- R8: An access to an index that is not implemented raises `fault` and returns zero read data.
- R9: `rd_data` and `fault` are registered and reflect the access one cycle after the strobe. `fault` stays high for exactly one cycle per refused access. `rd_data` is zero in any cycle that does not follow a granted read.
- R10: After reset, each register holds (index << 8). The non-secure copy of a split register also has bit 16 set. The copy-select bit is therefore 0, which selects the secure copy.
- R11: When read and write strobes are both set for the same register, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx | input | IDX_W | Register index |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| core_ns | input | 1 | Core is in the non-secure world |
| mon_mode | input | 1 | Core is in monitor mode |
| rd_data | output | DATA_W | Registered read data |
| fault | output | 1 | Registered one-cycle access fault |

## Verification
The bench sweeps every index through every combination of monitor mode, core world and copy-select value. It keeps its own model of the register contents and, after each write, reads back through the port.

- A design that let monitor mode follow the core world instead of the copy-select bit would return the wrong copy in the monitor passes where the two disagree.
- A design that honoured the copy-select bit outside monitor mode would cross worlds in the passes with the bit set.
- Writes from the non-secure world that aim at protected register 0 try to flip the copy-select bit. A later monitor read of a split register would expose any leak.
- A design that stored the write before the read, or let a refused access return stale data or hold the fault high, would show it at the same-cycle read-write case and the idle cycles after faulting accesses.

// File: rtl/sbr_pkg.sv
// Shared types and reset-value arithmetic for the two-world register file.
// Assumes register values are at most 64 bits wide before truncation.
package sbr_pkg;

    // Access class of a register index.
    typedef enum logic [1:0] {
        CLS_PROT   = 2'd0,
        CLS_SPLIT  = 2'd1,
        CLS_SHARED = 2'd2,
        CLS_NONE   = 2'd3
    } reg_class_e;

    // Reset value: index in bits 8 and up, bit 16 set for a non-secure copy.
    function automatic logic [63:0] rst_val(input int unsigned index, input logic ns_copy);
        return (64'(index) << 8) | (64'(ns_copy) << 16);
    endfunction

endpackage

// File: rtl/sbr_decode.sv
// Index decoder: maps a register index to its class and its slot within the class.
// Assumes classes are laid out contiguously: protected, then split, then shared.
module sbr_decode
    import sbr_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int N_PROT   = 2,
    parameter int N_SPLIT  = 3,
    parameter int N_SHARED = 2,
    parameter int SLOT_W   = 2
) (
    input  logic [IDX_W-1:0]  idx,
    output reg_class_e        cls,
    output logic [SLOT_W-1:0] slot
);
    localparam int SPLIT_BASE  = N_PROT;
    localparam int SHARED_BASE = N_PROT + N_SPLIT;
    localparam int IMPL_END    = N_PROT + N_SPLIT + N_SHARED;

    // Range compare of the index against the class boundaries.
    always_comb begin
        int iv;
        iv   = int'(idx);
        cls  = CLS_NONE;
        slot = '0;
        if (iv < SPLIT_BASE) begin
            cls  = CLS_PROT;
            slot = SLOT_W'(iv);
        end else if (iv < SHARED_BASE) begin
            cls  = CLS_SPLIT;
            slot = SLOT_W'(iv - SPLIT_BASE);
        end else if (iv < IMPL_END) begin
            cls  = CLS_SHARED;
            slot = SLOT_W'(iv - SHARED_BASE);
        end
    end
endmodule

// File: rtl/sbr_world.sv
// World arbiter: decides the effective security of an access, which copy of a
// split register it reaches, and whether the access must be refused.
// Assumes monitor mode always counts as secure.
module sbr_world
    import sbr_pkg::*;
(
    input  logic       req,
    input  reg_class_e cls,
    input  logic       core_ns,
    input  logic       mon_mode,
    input  logic       sel_bit,
    output logic       use_ns_copy,
    output logic       deny
);
    logic eff_secure;

    // Effective security and copy choice.
    always_comb begin
        eff_secure  = mon_mode | ~core_ns;
        use_ns_copy = mon_mode ? sel_bit : core_ns;
    end

    // Refusal: unimplemented index, or protected register from the non-secure world.
    always_comb begin
        deny = 1'b0;
        if (req) begin
            if (cls == CLS_NONE) begin
                deny = 1'b1;
            end else if (cls == CLS_PROT && !eff_secure) begin
                deny = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbr_storage.sv
// Register storage: protected registers, both copies of each split register and
// the shared registers, with reset values and a combinational read mux.
// Assumes the write enable has already been qualified by the world arbiter, and N_PROT >= 1.
module sbr_storage
    import sbr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int N_PROT   = 2,
    parameter int N_SPLIT  = 3,
    parameter int N_SHARED = 2,
    parameter int SLOT_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  reg_class_e        cls,
    input  logic [SLOT_W-1:0] slot,
    input  logic              use_ns_copy,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_val,
    output logic              sel_bit
);
    localparam int SPLIT_BASE  = N_PROT;
    localparam int SHARED_BASE = N_PROT + N_SPLIT;

    logic [DATA_W-1:0] prot_q   [N_PROT];
    logic [DATA_W-1:0] split_s_q[N_SPLIT];
    logic [DATA_W-1:0] split_n_q[N_SPLIT];
    logic [DATA_W-1:0] shared_q [N_SHARED];

    genvar gi;
    generate
        for (gi = 0; gi < N_PROT; gi++) begin : g_prot
            // Protected register gi: single copy, secure writes only.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prot_q[gi] <= DATA_W'(rst_val(gi, 1'b0));
                end else if (we && cls == CLS_PROT && slot == SLOT_W'(gi)) begin
                    prot_q[gi] <= wr_data;
                end
            end
        end
        for (gi = 0; gi < N_SPLIT; gi++) begin : g_split
            // Split register gi: secure copy.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    split_s_q[gi] <= DATA_W'(rst_val(SPLIT_BASE + gi, 1'b0));
                end else if (we && cls == CLS_SPLIT && slot == SLOT_W'(gi) && !use_ns_copy) begin
                    split_s_q[gi] <= wr_data;
                end
            end
            // Split register gi: non-secure copy.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    split_n_q[gi] <= DATA_W'(rst_val(SPLIT_BASE + gi, 1'b1));
                end else if (we && cls == CLS_SPLIT && slot == SLOT_W'(gi) && use_ns_copy) begin
                    split_n_q[gi] <= wr_data;
                end
            end
        end
        for (gi = 0; gi < N_SHARED; gi++) begin : g_shared
            // Shared register gi: one location for both worlds.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shared_q[gi] <= DATA_W'(rst_val(SHARED_BASE + gi, 1'b0));
                end else if (we && cls == CLS_SHARED && slot == SLOT_W'(gi)) begin
                    shared_q[gi] <= wr_data;
                end
            end
        end
    endgenerate

    // Read mux over class, slot and copy.
    always_comb begin
        rd_val = '0;
        case (cls)
            CLS_PROT: begin
                for (int i = 0; i < N_PROT; i++) begin
                    if (slot == SLOT_W'(i)) rd_val = prot_q[i];
                end
            end
            CLS_SPLIT: begin
                for (int i = 0; i < N_SPLIT; i++) begin
                    if (slot == SLOT_W'(i)) rd_val = use_ns_copy ? split_n_q[i] : split_s_q[i];
                end
            end
            CLS_SHARED: begin
                for (int i = 0; i < N_SHARED; i++) begin
                    if (slot == SLOT_W'(i)) rd_val = shared_q[i];
                end
            end
            default: rd_val = '0;
        endcase
    end

    // Copy-select bit lives in bit 0 of protected register 0.
    always_comb sel_bit = prot_q[0][0];
endmodule

// File: rtl/sbr_regfile.sv
// Two-world configuration register file top: decodes the index, arbitrates the
// world, stores the registers and registers read data and the fault flag.
// Assumes one access per cycle; a simultaneous read and write target the same index.
module sbr_regfile
    import sbr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4,
    parameter int N_PROT   = 2,
    parameter int N_SPLIT  = 3,
    parameter int N_SHARED = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              core_ns,
    input  logic              mon_mode,
    output logic [DATA_W-1:0] rd_data,
    output logic              fault
);
    localparam int MAX_A  = (N_PROT > N_SPLIT) ? N_PROT : N_SPLIT;
    localparam int MAX_N  = (MAX_A > N_SHARED) ? MAX_A : N_SHARED;
    localparam int SLOT_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

    reg_class_e        cls;
    logic [SLOT_W-1:0] slot;
    logic              use_ns_copy;
    logic              deny;
    logic              sel_bit;
    logic [DATA_W-1:0] rd_val;
    logic              req;
    logic              we_ok;
    logic [DATA_W-1:0] rd_q;
    logic              fault_q;

    // Access request and granted write.
    always_comb begin
        req   = rd_en | wr_en;
        we_ok = wr_en & ~deny;
    end

    sbr_decode #(
        .IDX_W(IDX_W), .N_PROT(N_PROT), .N_SPLIT(N_SPLIT),
        .N_SHARED(N_SHARED), .SLOT_W(SLOT_W)
    ) u_decode (
        .idx (idx),
        .cls (cls),
        .slot(slot)
    );

    sbr_world u_world (
        .req        (req),
        .cls        (cls),
        .core_ns    (core_ns),
        .mon_mode   (mon_mode),
        .sel_bit    (sel_bit),
        .use_ns_copy(use_ns_copy),
        .deny       (deny)
    );

    sbr_storage #(
        .DATA_W(DATA_W), .N_PROT(N_PROT), .N_SPLIT(N_SPLIT),
        .N_SHARED(N_SHARED), .SLOT_W(SLOT_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (we_ok),
        .cls        (cls),
        .slot       (slot),
        .use_ns_copy(use_ns_copy),
        .wr_data    (wr_data),
        .rd_val     (rd_val),
        .sel_bit    (sel_bit)
    );

    // Output stage: registered read data (zero unless granted read) and fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            fault_q <= deny;
            rd_q    <= (rd_en && !deny) ? rd_val : '0;
        end
    end

    assign rd_data = rd_q;
    assign fault   = fault_q;
endmodule

// File: rtl/sbr_regfile_checker.sv
// Property checker for the two-world register file, attached to the top by bind.
// Assumes default class layout: protected, then split, then shared indices.
module sbr_regfile_checker #(
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4,
    parameter int N_PROT   = 2,
    parameter int N_SPLIT  = 3,
    parameter int N_SHARED = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  idx,
    input logic              rd_en,
    input logic              wr_en,
    input logic              core_ns,
    input logic              mon_mode,
    input logic [DATA_W-1:0] rd_data,
    input logic              fault,
    input logic              sel_bit
);
    localparam int N_IMPL = N_PROT + N_SPLIT + N_SHARED;

    // R8: unimplemented index faults on the next cycle.
    p_unimpl_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && int'(idx) >= N_IMPL) |=> fault);

    // R5: non-secure access to a protected register faults.
    p_prot_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && core_ns && !mon_mode && int'(idx) < N_PROT) |=> fault);

    // R4: monitor mode reaches protected registers without a fault.
    p_mon_prot_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && mon_mode && int'(idx) < N_PROT) |=> !fault);

    // R9: a fault follows an access strobe.
    p_fault_needs_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(rd_en || wr_en));

    // R9: read data is zero after a cycle without a read strobe.
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> rd_data == '0);

    // R5: a refused read returns zero.
    p_fault_zero_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> rd_data == '0);

    // R7: non-secure code outside monitor mode cannot change the copy-select bit.
    p_sel_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ns && !mon_mode) |=> $stable(sel_bit));
endmodule

bind sbr_regfile sbr_regfile_checker #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .N_PROT(N_PROT),
    .N_SPLIT(N_SPLIT), .N_SHARED(N_SHARED)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (idx),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .core_ns (core_ns),
    .mon_mode(mon_mode),
    .rd_data (rd_data),
    .fault   (fault),
    .sel_bit (sel_bit)
);

// File: tb/sbr_regfile_test.sv
// Sweep bench for the two-world register file with its own register model.
module sbr_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  idx = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        core_ns = 1'b0;
    logic        mon_mode = 1'b0;
    logic [31:0] rd_data;
    logic        fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_prot [2];
    logic [31:0] m_split[2][3];
    logic [31:0] m_shared[2];

    always #10 clk = ~clk;

    sbr_regfile uut (
        .clk(clk), .rst_n(rst_n), .idx(idx), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .core_ns(core_ns), .mon_mode(mon_mode),
        .rd_data(rd_data), .fault(fault)
    );

    function automatic string tag_of(int i, bit ns, bit mon);
        if (i >= 7) return "R8";
        if (i < 2) begin
            if (!mon && ns) return "R5";
            if (mon) return "R4";
            return (i == 0) ? "R7" : "R1";
        end
        if (i < 5) return mon ? "R3" : "R2";
        return "R6";
    endfunction

    task automatic check(string tag, logic [31:0] act_d, logic [31:0] exp_d, bit act_f, bit exp_f);
        checks++;
        if (act_d !== exp_d || act_f !== exp_f) begin
            errors++;
            $display("FAIL %s: rd_data=%h fault=%0b expected rd_data=%h fault=%0b",
                     tag, act_d, act_f, exp_d, exp_f);
        end
    endtask

    // One access: drive at a falling edge, check at the next falling edge.
    task automatic acc(int i, bit rd, bit wr, logic [31:0] d, bit ns, bit mon, string extra);
        bit eff_sec;
        bit bnk;
        bit efault;
        logic [31:0] old;
        logic [31:0] erd;
        eff_sec = mon || !ns;
        bnk     = mon ? m_prot[0][0] : ns;
        efault  = (i >= 7) || (i < 2 && !eff_sec);
        old     = '0;
        if (i < 2)      old = m_prot[i];
        else if (i < 5) old = m_split[bnk][i-2];
        else if (i < 7) old = m_shared[i-5];
        erd = (rd && !efault) ? old : 32'h0;
        if (wr && !efault) begin
            if (i < 2)      m_prot[i] = d;
            else if (i < 5) m_split[bnk][i-2] = d;
            else            m_shared[i-5] = d;
        end
        @(negedge clk);
        idx = 4'(i); rd_en = rd; wr_en = wr; wr_data = d; core_ns = ns; mon_mode = mon;
        @(negedge clk);
        check({tag_of(i, ns, mon), " ", extra}, rd_data, erd, fault, efault);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic idle_check(string tag);
        @(negedge clk);
        check(tag, rd_data, 32'h0, fault, 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R10: model reset values arithmetically.
        for (int i = 0; i < 2; i++) m_prot[i] = 32'(i) << 8;
        for (int j = 0; j < 3; j++) begin
            m_split[0][j] = 32'(j + 2) << 8;
            m_split[1][j] = (32'(j + 2) << 8) | 32'h1_0000;
        end
        for (int k = 0; k < 2; k++) m_shared[k] = 32'(k + 5) << 8;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset outputs", rd_data, 32'h0, fault, 1'b0);

        // R10: reset values seen from each view.
        for (int i = 0; i < 16; i++) acc(i, 1, 0, 0, 0, 0, "R10 secure view");
        for (int i = 0; i < 16; i++) acc(i, 1, 0, 0, 1, 0, "R10 non-secure view");
        for (int i = 2; i < 5; i++) acc(i, 1, 0, 0, 0, 1, "R10 select resets secure");

        // Sweep: monitor mode, core world, copy-select value.
        for (int cfg = 0; cfg < 8; cfg++) begin
            bit mon = cfg[2];
            bit ns  = cfg[1];
            bit sv  = cfg[0];
            acc(0, 0, 1, 32'hC000_0000 | 32'(sv), 0, 1, "R7 set select");
            for (int i = 0; i < 16; i++) begin
                logic [31:0] d;
                d = 32'h5000_0000 | (32'(cfg) << 12) | (32'(i) << 4) | 32'(!sv);
                acc(i, 0, 1, d, ns, mon, "write");
                acc(i, 1, 0, 0, ns, mon, "readback");
            end
            for (int i = 0; i < 7; i++) begin
                acc(i, 1, 0, 0, 0, 0, "cross secure");
                acc(i, 1, 0, 0, 1, 0, "cross non-secure");
            end
        end

        // R7: non-secure attempt to flip the select bit, then monitor probe.
        acc(0, 0, 1, 32'h0, 0, 0, "R7 clear select");
        acc(0, 0, 1, 32'h1, 1, 0, "R7 ns write refused");
        acc(3, 1, 0, 0, 0, 1, "R7 probe reaches secure copy");
        acc(0, 1, 0, 0, 0, 1, "R7 select still 0");

        // R6: shared register written from both worlds.
        acc(5, 0, 1, 32'hAAAA_0005, 1, 0, "R6 ns write");
        acc(5, 1, 0, 0, 0, 0, "R6 secure read");
        acc(6, 0, 1, 32'hBBBB_0006, 0, 0, "R6 secure write");
        acc(6, 1, 0, 0, 1, 0, "R6 ns read");

        // R11: simultaneous read and write returns the old value.
        acc(5, 1, 1, 32'h1234_5678, 0, 0, "R11 read old");
        acc(5, 1, 0, 0, 1, 0, "R11 new value stored");
        acc(3, 1, 1, 32'h8765_4321, 1, 0, "R11 split read old");
        acc(3, 1, 0, 0, 1, 0, "R11 split new value");

        // R9: idle cycles after a read and after a fault.
        acc(4, 1, 0, 0, 0, 0, "R9 read");
        idle_check("R9 idle after read");
        acc(9, 1, 0, 0, 0, 0, "R9 fault");
        idle_check("R9 fault one cycle");
        acc(1, 1, 1, 32'hFFFF_FFFF, 1, 0, "R9 refused rd+wr");
        idle_check("R9 fault one cycle again");
        acc(1, 1, 0, 0, 0, 0, "R5 protected unchanged");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule